// File: doc/BRIEF.md
# CSR Access Instruction Executor

This block executes the three control-status-register access instructions: swap, set bits and clear bits. Each comes in a form that takes its operand from a register and a form that takes a 5-bit immediate. A pipeline hands it one instruction word, together with the value of the source register and the current privilege level. The block reads the addressed register from an external register file, decides whether the access writes, and computes the new value. It writes that value back through a write port and returns the old value for the destination register. When the access rights do not permit the access, it reports an illegal instruction instead.

The block is a small state machine with five named states:
- `ST_IDLE` waits for `issue_valid`. It moves to `ST_READ` for a permitted access, to `ST_FAULT` for a refused one, and to `ST_PASS` for a word that is not a register access.
- `ST_READ` presents the address and captures the old value, then moves to `ST_COMMIT`.
- `ST_COMMIT`, `ST_FAULT` and `ST_PASS` each last one cycle with `done` high, then return to `ST_IDLE`.

Top module: `csr_exec`

## Requirements
- R1: A word is an access only when bits [6:0] equal 7'b1110011 and bits [13:12] are nonzero. Any other word gives `not_mine` and `done` one cycle after issue, with no register-file write, no destination write and no `illegal`.
- R2: When bit 14 is 1, the operand is bits [19:15] zero-extended to XLEN. When bit 14 is 0, the operand is `rs1_val`.
- R3: Swap (bits [13:12] = 2'b01) always writes. Set (2'b10) and clear (2'b11) write only when bits [19:15] are nonzero, in both the register and the immediate form.
- R4: The value written is the operand for swap, old OR operand for set, and old AND NOT operand for clear. It is written to address bits [31:20].
- R5: The destination (bits [11:7]) receives the old value read before any write. `rd_wen` stays low when the destination field is 0.
- R6: When address bits [9:8], read as an unsigned number, exceed `priv` (0 user, 1 supervisor, 3 machine), the block raises `illegal` together with `done` and makes no writes.
- R7: When address bits [11:10] are 2'b11 and the access would write, the block raises `illegal` and makes no writes. A non-writing access to such an address completes normally.
- R8: For a permitted access, `csr_raddr` carries the address in the first cycle after issue, and the result appears with `done` in the second cycle. `busy` is high from issue until `done`, and `issue_valid` is ignored while `busy` is high.
- R9: After reset the block is idle, with `busy`, `done`, `csr_wen`, `rd_wen`, `illegal` and `not_mine` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Source register value |
| priv | input | 2 | Current privilege level |
| busy | output | 1 | Instruction in flight |
| csr_raddr | output | 12 | Register-file read address |
| csr_rdata | input | XLEN | Register-file read data (combinational) |
| csr_waddr | output | 12 | Register-file write address |
| csr_wdata | output | XLEN | Register-file write data |
| csr_wen | output | 1 | Register-file write enable |
| rd_addr | output | 5 | Destination register index |
| rd_wdata | output | XLEN | Destination value (old contents) |
| rd_wen | output | 1 | Destination write enable |
| illegal | output | 1 | Access refused |
| not_mine | output | 1 | Word is not a register access |
| done | output | 1 | Result cycle |

## Verification
The bench builds the block with the default XLEN of 32. At that width the immediate fills only the low five bits of the operand, so the zero-extension boundary can be seen. A clear with immediate 31 applied to an all-ones value must leave exactly bits [31:5] set. The 32-bit width also lets the bench choose source-register values that are nonzero while the source index is zero, which shows that the write decision follows the field and not the value.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
    localparam int         ADDR_W     = 12;
    localparam int         IDX_W      = 5;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COMMIT,
        ST_FAULT,
        ST_PASS
    } exec_state_t;

    typedef struct packed {
        logic                is_access;
        logic [ADDR_W-1:0]   addr;
        logic [IDX_W-1:0]    src_idx;
        logic                use_imm;
        csr_op_t             op;
        logic [IDX_W-1:0]    dst;
    } csr_dec_t;

endpackage

// File: rtl/csr_exec_decode.sv
module csr_exec_decode
    import csr_exec_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [1:0]  priv,
    output csr_dec_t    dec,
    output logic        write_intent,
    output logic        access_ok
);

    logic need_priv_fail;
    logic ro_fail;

    always_comb begin
        dec.addr      = instr[31:20];
        dec.src_idx   = instr[19:15];
        dec.use_imm   = instr[14];
        dec.op        = csr_op_t'(instr[13:12]);
        dec.dst       = instr[11:7];
        dec.is_access = (instr[6:0] == OPC_SYSTEM) && (instr[13:12] != 2'b00);
    end

    // swap always writes; set/clear only with a nonzero source field
    assign write_intent   = dec.is_access &&
                            ((dec.op == OP_SWAP) || (dec.src_idx != '0));
    assign need_priv_fail = (dec.addr[9:8] > priv);
    assign ro_fail        = write_intent && (dec.addr[11:10] == 2'b11);
    assign access_ok      = !need_priv_fail && !ro_fail;

endmodule

// File: rtl/csr_exec_operand.sv
module csr_exec_operand
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             use_imm,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [XLEN-1:0]  rs1_val,
    output logic [XLEN-1:0]  operand
);

    logic [XLEN-1:0] imm_ext;

    generate
        if (XLEN > IDX_W) begin : g_wide
            assign imm_ext = {{(XLEN-IDX_W){1'b0}}, src_idx};
        end else begin : g_narrow
            assign imm_ext = src_idx[XLEN-1:0];
        end
    endgenerate

    assign operand = use_imm ? imm_ext : rs1_val;

endmodule

// File: rtl/csr_exec_alu.sv
module csr_exec_alu
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_t         op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] new_val
);

    always_comb begin
        unique case (op)
            OP_SWAP: new_val = operand;
            OP_SET:  new_val = old_val | operand;
            OP_CLR:  new_val = old_val & ~operand;
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/csr_exec.sv
module csr_exec
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [31:0]         instr,
    input  logic [XLEN-1:0]     rs1_val,
    input  logic [1:0]          priv,
    output logic                busy,
    output logic [ADDR_W-1:0]   csr_raddr,
    input  logic [XLEN-1:0]     csr_rdata,
    output logic [ADDR_W-1:0]   csr_waddr,
    output logic [XLEN-1:0]     csr_wdata,
    output logic                csr_wen,
    output logic [IDX_W-1:0]    rd_addr,
    output logic [XLEN-1:0]     rd_wdata,
    output logic                rd_wen,
    output logic                illegal,
    output logic                not_mine,
    output logic                done
);

    exec_state_t     state_q, state_d;
    csr_dec_t        dec, dec_q;
    logic            wi, wi_q;
    logic            ok;
    logic [XLEN-1:0] operand, src_q, old_q, new_val;
    logic            accept;

    csr_exec_decode u_decode (
        .instr        (instr),
        .priv         (priv),
        .dec          (dec),
        .write_intent (wi),
        .access_ok    (ok)
    );

    csr_exec_operand #(.XLEN(XLEN)) u_operand (
        .use_imm (dec.use_imm),
        .src_idx (dec.src_idx),
        .rs1_val (rs1_val),
        .operand (operand)
    );

    csr_exec_alu #(.XLEN(XLEN)) u_alu (
        .op      (dec_q.op),
        .old_val (old_q),
        .operand (src_q),
        .new_val (new_val)
    );

    assign accept = issue_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (!dec.is_access) state_d = ST_PASS;
                    else if (!ok)       state_d = ST_FAULT;
                    else                state_d = ST_READ;
                end
            end
            ST_READ:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            ST_PASS:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
            wi_q  <= 1'b0;
            src_q <= '0;
            old_q <= '0;
        end else begin
            if (accept) begin
                dec_q <= dec;
                wi_q  <= wi;
                src_q <= operand;
            end
            if (state_q == ST_READ) old_q <= csr_rdata;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        csr_raddr = dec_q.addr;
        csr_waddr = dec_q.addr;
        csr_wdata = new_val;
        rd_addr   = dec_q.dst;
        rd_wdata  = old_q;
        csr_wen   = 1'b0;
        rd_wen    = 1'b0;
        illegal   = 1'b0;
        not_mine  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_COMMIT: begin
                done    = 1'b1;
                csr_wen = wi_q;
                rd_wen  = (dec_q.dst != '0);
            end
            ST_FAULT: begin
                done    = 1'b1;
                illegal = 1'b1;
            end
            ST_PASS: begin
                done     = 1'b1;
                not_mine = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/csr_exec_chk.sv
module csr_exec_chk
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                issue_valid,
    input logic                busy,
    input logic [ADDR_W-1:0]   csr_waddr,
    input logic [XLEN-1:0]     csr_rdata,
    input logic                csr_wen,
    input logic [IDX_W-1:0]    rd_addr,
    input logic [XLEN-1:0]     rd_wdata,
    input logic                rd_wen,
    input logic                illegal,
    input logic                not_mine,
    input logic                done
);

    AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({illegal, not_mine})); // R1

    AST_PASS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        not_mine |-> (!csr_wen && !rd_wen)); // R1

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!csr_wen && !rd_wen)); // R6

    AST_RO_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wen |-> (csr_waddr[11:10] != 2'b11)); // R7

    AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wen |-> (rd_addr != '0)); // R5

    AST_RD_GETS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_wen && $past(busy)) |-> (rd_wdata == $past(csr_rdata))); // R5

    AST_WRITES_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen || rd_wen || illegal || not_mine) |-> done); // R8

    AST_ISSUE_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !busy) |=> busy); // R8

    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8

endmodule

bind csr_exec csr_exec_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .busy        (busy),
    .csr_waddr   (csr_waddr),
    .csr_rdata   (csr_rdata),
    .csr_wen     (csr_wen),
    .rd_addr     (rd_addr),
    .rd_wdata    (rd_wdata),
    .rd_wen      (rd_wen),
    .illegal     (illegal),
    .not_mine    (not_mine),
    .done        (done)
);

// File: tb/test_csr_exec.sv
`timescale 1ns/1ps
module test_csr_exec;

    localparam int XLEN = 32;

    typedef struct packed {
        logic        illegal;
        logic        not_mine;
        logic        wen;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic        rdw;
        logic [4:0]  rd;
        logic [31:0] rdv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [1:0]  priv = 2'b11;
    logic [31:0] file_val = '0;
    logic        busy, csr_wen, rd_wen, illegal, not_mine, done;
    logic [11:0] csr_raddr, csr_waddr;
    logic [31:0] csr_wdata, rd_wdata;
    logic [4:0]  rd_addr;

    int   errors = 0;
    int   checks = 0;
    int   cycles = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    csr_exec #(.XLEN(XLEN)) i_csr_exec (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .rs1_val(rs1_val), .priv(priv), .busy(busy), .csr_raddr(csr_raddr),
        .csr_rdata(file_val), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
        .csr_wen(csr_wen), .rd_addr(rd_addr), .rd_wdata(rd_wdata),
        .rd_wen(rd_wen), .illegal(illegal), .not_mine(not_mine), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                       input logic imm, input logic [1:0] op,
                                       input logic [4:0] rd);
        return {a, s, imm, op, rd, 7'b1110011};
    endfunction

    function automatic exp_t predict(input logic [31:0] w, input logic [31:0] r,
                                     input logic [1:0] p, input logic [31:0] oldv);
        exp_t e;
        logic [31:0] src;
        logic wi;
        e = '0;
        e.addr = w[31:20];
        e.rd   = w[11:7];
        if (w[6:0] != 7'b1110011 || w[13:12] == 2'b00) begin
            e.not_mine = 1'b1;
            return e;
        end
        src = w[14] ? {27'b0, w[19:15]} : r;
        wi  = (w[13:12] == 2'b01) || (w[19:15] != 5'd0);
        if (w[29:28] > p || (wi && w[31:30] == 2'b11)) begin
            e.illegal = 1'b1;
            return e;
        end
        e.wen = wi;
        case (w[13:12])
            2'b01:   e.wdata = src;
            2'b10:   e.wdata = oldv | src;
            default: e.wdata = oldv & ~src;
        endcase
        e.rdw = (w[11:7] != 5'd0);
        e.rdv = oldv;
        return e;
    endfunction

    task automatic issue(input logic [31:0] w, input logic [31:0] r,
                         input logic [1:0] p, input logic [31:0] oldv,
                         input bit poke);
        sb_q.push_back(predict(w, r, p, oldv));
        @(negedge clk);
        instr = w; rs1_val = r; priv = p; file_val = oldv; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        if (poke) begin
            // R8: a second offer while busy must be ignored
            instr = mk(12'h340, 5'd3, 1'b0, 2'b01, 5'd9);
            rs1_val = 32'hDEAD_BEEF;
            issue_valid = 1'b1;
            @(negedge clk);
            issue_valid = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !done) begin
                if (sb_q.size() == 0) chk(1'b0, "R8 busy with nothing issued", 32'(busy), 32'd0);
                else chk(csr_raddr == sb_q[0].addr, "R8 read address",
                         32'(csr_raddr), 32'(sb_q[0].addr));
            end
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", 32'(done), 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(not_mine == e.not_mine, "R1 not_mine", 32'(not_mine), 32'(e.not_mine));
                    chk(illegal == e.illegal, "R6/R7 illegal", 32'(illegal), 32'(e.illegal));
                    chk(csr_wen == e.wen, "R3 write enable", 32'(csr_wen), 32'(e.wen));
                    if (e.wen) begin
                        chk(csr_wdata == e.wdata, "R2/R4 write data", csr_wdata, e.wdata);
                        chk(csr_waddr == e.addr, "R4 write address", 32'(csr_waddr), 32'(e.addr));
                    end
                    chk(rd_wen == e.rdw, "R5 rd enable", 32'(rd_wen), 32'(e.rdw));
                    if (e.rdw) begin
                        chk(rd_wdata == e.rdv, "R5 rd value", rd_wdata, e.rdv);
                        chk(rd_addr == e.rd, "R5 rd index", 32'(rd_addr), 32'(e.rd));
                    end
                end
            end
        end
    end

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            chk(1'b0, "watchdog expired", 32'(cycles), 32'd20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({busy, done, csr_wen, rd_wen, illegal, not_mine} == 6'b0, "R9 reset outputs",
            32'({busy, done, csr_wen, rd_wen, illegal, not_mine}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after reset", 32'(busy), 32'd0);

        // R4 swap, register form
        issue(mk(12'h340, 5'd4, 1'b0, 2'b01, 5'd5), 32'hA5A5_0F0F, 2'd3, 32'h0000_1234, 1'b0);
        // R4 set, register form
        issue(mk(12'h341, 5'd7, 1'b0, 2'b10, 5'd6), 32'h0000_00F0, 2'd3, 32'h0000_000F, 1'b0);
        // R4 clear, register form
        issue(mk(12'h342, 5'd8, 1'b0, 2'b11, 5'd6), 32'hFF00_00FF, 2'd3, 32'h1234_5678, 1'b0);
        // R2 clear with immediate 31 at the extension boundary
        issue(mk(12'h343, 5'h1F, 1'b1, 2'b11, 5'd2), 32'h0000_0000, 2'd3, 32'hFFFF_FFFF, 1'b0);
        // R2 set with immediate ignores rs1_val
        issue(mk(12'h344, 5'h12, 1'b1, 2'b10, 5'd2), 32'hFFFF_FFFF, 2'd3, 32'h0000_0100, 1'b0);
        // R3 set from x0 with a nonzero register value: no write
        issue(mk(12'h340, 5'd0, 1'b0, 2'b10, 5'd3), 32'h0000_FFFF, 2'd3, 32'h0000_0042, 1'b0);
        // R3 clear with immediate zero: no write
        issue(mk(12'h340, 5'd0, 1'b1, 2'b11, 5'd3), 32'h0000_0000, 2'd3, 32'h0000_0077, 1'b0);
        // R3 swap with immediate zero still writes zero
        issue(mk(12'h340, 5'd0, 1'b1, 2'b01, 5'd3), 32'h0000_0000, 2'd3, 32'h0000_0055, 1'b0);
        // R5 destination x0 is not written
        issue(mk(12'h340, 5'd1, 1'b0, 2'b01, 5'd0), 32'h0000_0011, 2'd3, 32'h0000_0022, 1'b0);
        // R6 machine register from supervisor level
        issue(mk(12'h300, 5'd1, 1'b0, 2'b01, 5'd4), 32'h1, 2'd1, 32'h9, 1'b0);
        // R6 supervisor register from supervisor: permitted
        issue(mk(12'h100, 5'd1, 1'b0, 2'b10, 5'd4), 32'h8, 2'd1, 32'h1, 1'b0);
        // R6 supervisor register from user level
        issue(mk(12'h100, 5'd0, 1'b0, 2'b10, 5'd4), 32'h8, 2'd0, 32'h1, 1'b0);
        // R7 read-only register read without write intent
        issue(mk(12'hC00, 5'd0, 1'b0, 2'b10, 5'd10), 32'h5, 2'd0, 32'h0000_BEEF, 1'b0);
        // R7 read-only register swapped
        issue(mk(12'hC00, 5'd2, 1'b0, 2'b01, 5'd10), 32'h5, 2'd0, 32'h0000_BEEF, 1'b0);
        // R7 machine read-only register, set with nonzero immediate
        issue(mk(12'hF11, 5'd1, 1'b1, 2'b10, 5'd10), 32'h0, 2'd3, 32'h0, 1'b0);
        // R1 funct3 000, funct3 100, foreign opcode
        issue(32'h0000_0073, 32'h0, 2'd3, 32'h0, 1'b0);
        issue(32'h3400_4073, 32'h0, 2'd3, 32'h0, 1'b0);
        issue(32'h3401_1033, 32'h0, 2'd3, 32'h0, 1'b0);
        // R8 offer while busy is ignored
        issue(mk(12'h341, 5'd9, 1'b0, 2'b01, 5'd12), 32'h0BAD_F00D, 2'd3, 32'h0000_0001, 1'b1);

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R8 all results seen", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule